// File: doc/BRIEF.md
# Width-Programmable Serializer With Load Strobe

This block converts parallel words into a serial bit stream at one bit per clock. A 3-bit size code selects a word length of 4, 5, 8 or 10 bits. The two short lengths take their bits from a narrow lane bus, and the two long lengths take them from a separate wide lane bus. A long word is sent with its upper lane group first, followed by its lower group.

The block tells upstream logic when to present the next word through a one-cycle ready pulse. The word is taken on the clock edge that ends that pulse, and its first bit leaves on the very next cycle, so there is no gap between words. A frame-sync output marks each word boundary one clock early, which is the form a matching deserializer's frame input expects.

The serial line can never stall, so the stream interface has no back-pressure in the usual sense. `in_ready` is a fixed-rate pulse, and a word is accepted only if `in_valid` is high in that same cycle. When `in_valid` is low at the pulse, the block sends a word of zeros of the selected length instead. Upstream must hold its data and `in_valid` through a pulse cycle. It must not expect the block to wait.

Top module: `serw_top`

## Requirements
- R1: The word length comes from `size_code[1:0]`: 00 gives 4, 01 gives 5, 10 gives 8 and 11 gives 10. `size_code[2]` has no effect, so code 1xx behaves exactly like 0xx.
- R2: For lengths 4 and 5, the serial bits are `nar_lanes[0]`, `nar_lanes[1]` and so on up to `nar_lanes[len-1]`, lowest index first.
- R3: For length 8, the serial order is `wide_lanes` 5, 6, 7, 8, then 0, 1, 2, 3.
- R4: For length 10, the serial order is `wide_lanes` 5, 6, 7, 8, 9, then 0, 1, 2, 3, 4.
- R5: `in_ready` is high for exactly one cycle: the cycle in which the last bit of the current word is on `ser_out`. The next word's first bit appears on `ser_out` in the following cycle, with no idle bit between words.
- R6: `frame_sync` is high in the same cycles as `in_ready`, which is one clock before each word boundary, and low otherwise.
- R7: If `in_valid` is low in a cycle where `in_ready` is high, the next word is all zeros of the selected length, and the lane buses are ignored.
- R8: While reset is low, and after it is released, `ser_out` stays 0 until the first word is sent. Before the first boundary the length is 4, so `in_ready` first goes high in the fourth cycle counted from the cycle in which reset is released.
- R9: The size code is sampled only on the edge that captures a word. A change in the middle of a word alters neither that word's length nor its bits.
- R10: Lanes outside the selected order are ignored: the whole wide bus at lengths 4 and 5, `nar_lanes[4]` at length 4, and `wide_lanes[4]` and `wide_lanes[9]` at length 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_code | input | 3 | Word length select (R1) |
| in_valid | input | 1 | Upstream word present during the ready pulse |
| in_ready | output | 1 | Load strobe: the word on the lane buses is taken at the end of this cycle |
| nar_lanes | input | 5 | Parallel lanes for 4- and 5-bit words |
| wide_lanes | input | 10 | Parallel lanes for 8- and 10-bit words |
| ser_out | output | 1 | Serial data, one bit per clock |
| frame_sync | output | 1 | High one clock before each word boundary |

## Verification
A size-code change and a word capture can land on the same edge. At that edge the new code must set the length of the word being captured, and must not cut short the word that is still going out.

The bench provokes this in two ways. It changes the code exactly in ready cycles while walking the vector table. It also changes the code partway through a 10-bit word and leaves it changed.

Both cases are judged bit by bit on `ser_out`, and by the position of the next `in_ready` pulse. The ongoing word must keep all ten bits, and the following word must take the new length.

// File: rtl/serw_pkg.sv
package serw_pkg;

  typedef enum logic [1:0] {
    SZ_N4  = 2'b00,
    SZ_N5  = 2'b01,
    SZ_W8  = 2'b10,
    SZ_W10 = 2'b11
  } size_e;

  // Word length for a size mode; grp is the lane-group width (5 by default).
  function automatic int word_len(size_e m, int grp);
    case (m)
      SZ_N4:   return grp - 1;
      SZ_N5:   return grp;
      SZ_W8:   return 2 * (grp - 1);
      default: return 2 * grp;
    endcase
  endfunction

endpackage

// File: rtl/serw_order.sv
module serw_order
  import serw_pkg::*;
#(
  parameter int GRP = 5,
  localparam int WMAX = 2 * GRP
) (
  input  size_e             mode,
  input  logic [GRP-1:0]    nar,
  input  logic [WMAX-1:0]   wide,
  output logic [WMAX-1:0]   ord
);

  int n_bits;
  int half;

  // ord[0] leaves first on the serial line
  always_comb begin
    ord    = '0;
    n_bits = word_len(mode, GRP);
    half   = n_bits / 2;
    if (mode == SZ_N4 || mode == SZ_N5) begin
      for (int i = 0; i < GRP; i++) begin
        if (i < n_bits) ord[i] = nar[i];
      end
    end else begin
      // upper lane group first, then lower group
      for (int i = 0; i < GRP; i++) begin
        if (i < half) begin
          ord[i]        = wide[GRP + i];
          ord[half + i] = wide[i];
        end
      end
    end
  end

endmodule

// File: rtl/serw_ctrl.sv
module serw_ctrl
  import serw_pkg::*;
#(
  parameter int GRP = 5,
  localparam int WMAX = 2 * GRP,
  localparam int CW = $clog2(WMAX + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  size_e mode,
  output logic  boundary
);

  logic [CW-1:0] bit_cnt;
  logic [CW-1:0] cur_len;

  assign boundary = (bit_cnt == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      cur_len <= CW'(GRP - 1);
    end else if (boundary) begin
      bit_cnt <= '0;
      cur_len <= CW'(word_len(mode, GRP));
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/serw_top.sv
module serw_top
  import serw_pkg::*;
#(
  parameter int GRP = 5,
  localparam int WMAX = 2 * GRP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      size_code,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [GRP-1:0]  nar_lanes,
  input  logic [WMAX-1:0] wide_lanes,
  output logic            ser_out,
  output logic            frame_sync
);

  size_e           mode;
  logic            boundary;
  logic [WMAX-1:0] ordered;
  logic [WMAX-1:0] shreg;
  logic            unused_size_hi;

  assign mode           = size_e'(size_code[1:0]);
  assign unused_size_hi = size_code[2];

  serw_ctrl #(.GRP(GRP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .boundary (boundary)
  );

  serw_order #(.GRP(GRP)) u_order (
    .mode (mode),
    .nar  (nar_lanes),
    .wide (wide_lanes),
    .ord  (ordered)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (boundary)
      shreg <= in_valid ? ordered : '0;
    else
      shreg <= shreg >> 1;
  end

  assign ser_out    = shreg[0];
  assign in_ready   = boundary;
  assign frame_sync = boundary;

endmodule

// File: rtl/serw_chk.sv
module serw_chk #(
  parameter int GRP = 5,
  localparam int WMAX = 2 * GRP,
  localparam int CW = $clog2(WMAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      size_code,
  input logic            in_valid,
  input logic            in_ready,
  input logic [GRP-1:0]  nar_lanes,
  input logic [WMAX-1:0] wide_lanes,
  input logic            ser_out,
  input logic            frame_sync
);

  logic [CW-1:0] gap;
  logic          seen;
  logic          len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= CW'(1);
      seen <= 1'b0;
    end else begin
      if (in_ready) begin
        gap  <= CW'(1);
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  assign len_ok = (gap == CW'(GRP - 1)) || (gap == CW'(GRP)) ||
                  (gap == CW'(2 * GRP - 2)) || (gap == CW'(2 * GRP));

  // R5: the load strobe is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R1: pulses are spaced by one of the legal word lengths
  a_r1_word_len: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> len_ok);

  // R8: first word after reset is four bits long
  a_r8_first_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !seen) |-> (gap == CW'(GRP - 1)));

  // R8: line idles at zero until a word is sent
  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !ser_out);

  // R7: missing word gives a zero first bit
  a_r7_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !ser_out);

  // R2: narrow words start with lane 0
  a_r2_narrow_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && !size_code[1]) |=> (ser_out == $past(nar_lanes[0])));

  // R3 / R4: wide words start with the first upper-group lane
  a_r3_wide_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && size_code[1]) |=> (ser_out == $past(wide_lanes[GRP])));

endmodule

bind serw_top serw_chk #(.GRP(GRP)) u_chk (.*);

// File: tb/serw_top_tb.sv
module serw_top_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] size_code;
  logic       in_valid;
  logic       in_ready;
  logic [4:0] nar_lanes;
  logic [9:0] wide_lanes;
  logic       ser_out;
  logic       frame_sync;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  serw_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_code  (size_code),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .nar_lanes  (nar_lanes),
    .wide_lanes (wide_lanes),
    .ser_out    (ser_out),
    .frame_sync (frame_sync)
  );

  // {size_code, in_valid, nar_lanes, wide_lanes}
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {3'b000, 1'b1, 5'b10110, 10'h3FF},  // R10: wide bus and nar[4] unused
    {3'b001, 1'b1, 5'b10011, 10'h000},  // R2
    {3'b010, 1'b1, 5'h1F,    10'h2D3},  // R10: lanes 4 and 9 unused at 8
    {3'b011, 1'b1, 5'h00,    10'h1A7},  // R4
    {3'b011, 1'b0, 5'h1F,    10'h3FF},  // R7
    {3'b111, 1'b1, 5'h00,    10'h0F1},  // R1: bit 2 ignored, length 10
    {3'b100, 1'b1, 5'b01101, 10'h3FF},  // R1: length 4
    {3'b101, 1'b1, 5'b11110, 10'h000},  // R1: length 5
    {3'b010, 1'b1, 5'h00,    10'h3C5}   // R3
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2:    return "R10";
      1:       return "R2";
      3:       return "R4";
      4:       return "R7";
      8:       return "R3";
      default: return "R1";
    endcase
  endfunction

  function automatic int len_of(logic [2:0] s);
    case (s[1:0])
      2'b00:   return 4;
      2'b01:   return 5;
      2'b10:   return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic exp_bit(logic [2:0] s, logic v, logic [4:0] n,
                                   logic [9:0] w, int k);
    if (!v) return 1'b0;
    case (s[1:0])
      2'b00, 2'b01: return n[k];
      2'b10:        return (k < 4) ? w[5 + k] : w[k - 4];
      default:      return (k < 5) ? w[5 + k] : w[k - 5];
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge where in_ready is high; drives the word, checks all bits.
  // chg_k >= 0: at that bit, drive chg_size and scramble lanes mid-word (R9).
  task automatic run_word(string tag, logic [2:0] s, logic v, logic [4:0] n,
                          logic [9:0] w, int chg_k, logic [2:0] chg_size);
    int len;
    len        = len_of(s);
    size_code  = s;
    in_valid   = v;
    nar_lanes  = n;
    wide_lanes = w;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(tag, ser_out, exp_bit(s, v, n, w, k));
      chk("R5 ready", in_ready, k == len - 1);
      chk("R6 sync", frame_sync, k == len - 1);
      if (k == chg_k) begin
        size_code  = chg_size;
        nar_lanes  = ~n;
        wide_lanes = ~w;
      end
    end
  endtask

  task automatic reset_and_wait;
    rst_n      = 1'b0;
    size_code  = 3'b011;
    in_valid   = 1'b1;
    nar_lanes  = 5'h1F;
    wide_lanes = 10'h3FF;
    repeat (2) @(negedge clk);
    chk("R8 reset ser", ser_out, 1'b0);
    chk("R8 reset ready", in_ready, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      if (c > 0) @(negedge clk);
      chk("R8 idle ser", ser_out, 1'b0);
      chk("R8 first ready", in_ready, c == 3);
    end
  endtask

  initial begin
    reset_and_wait();

    for (int i = 0; i < NV; i++) begin
      logic [18:0] e;
      e = VEC[i];
      run_word(vec_tag(i), e[18:16], e[15], e[14:10], e[9:0], -1, 3'b000);
    end

    // R9: size changes to 4 at bit 2 of a 10-bit word; that word keeps length and data
    run_word("R9", 3'b011, 1'b1, 5'h00, 10'h155, 2, 3'b000);
    // next word takes the new length 4
    run_word("R9", 3'b000, 1'b1, 5'b01011, 10'h000, -1, 3'b000);
    // back to back narrow 5 then wide 10 with no gap (R5)
    run_word("R5", 3'b001, 1'b1, 5'b10101, 10'h000, -1, 3'b000);
    run_word("R5", 3'b011, 1'b1, 5'h00, 10'h2AA, -1, 3'b000);

    // R8: reset in the middle of a word
    @(negedge clk);
    reset_and_wait();
    run_word("R8", 3'b010, 1'b1, 5'h00, 10'h0FF, -1, 3'b000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule